// File: doc/BRIEF.md
# Four-Way Exact Recency Replacement Tracker

This block holds the complete recency ranking of the ways in one cache set and names the way to evict when the set misses. Each stack position stores a way number. Position 0 is the most recently used way and the last position is the least recently used way. The client presents one access per cycle. The access carries a way number and a hit or miss flag. On a hit, the tracker promotes that way to the top. On a miss, it promotes the way it currently names as victim, because that way is the one being refilled. Ways that ranked above the promoted way sink by one position. Ways that ranked below it keep their positions.

The victim output is the way stored in the bottom stack position. It comes straight from the ordering register, so it is valid in the cycle in which a miss is presented. A cache with many sets instantiates one tracker per set, or stores the flat order word of each set in its own array and shares one tracker. The tracker does no tag comparison, stores no data and has no random replacement mode.

Top module: `lru_order_tracker`

## Requirements
- R1: A cycle with `rst` high loads the order with way p in stack position p, so that way 0 is the most recent way and way N_WAYS-1 is the victim. With the default of four ways, `order_flat` reads 8'hE4.
- R2: `order_flat` holds stack position p in bits [WAY_W*p+WAY_W-1 : WAY_W*p]. Position 0 is the most recent way and position N_WAYS-1 is the least recent way. `victim_way` always equals the field of the last position.
- R3: A hit on the way at stack position k changes the order in the next cycle. That way moves to position 0, the ways at positions 0..k-1 each move down one position, and positions above k keep their ways.
- R4: A miss promotes the current `victim_way` to position 0 in the next cycle, and every other way moves down one position. The value on `acc_way` has no effect during a miss.
- R5: In a cycle with `acc_valid` low, the order does not change. This includes a cycle in which a refill is still outstanding.
- R6: The order is always a permutation of the ways: every way number appears in exactly one stack position.
- R7: A hit on the way already in position 0 leaves the order unchanged.
- R8: This access sequence runs from the reset order and uses ways 0..3 for A..D. Each step gives the order shown, written most recent first.
  - A hit on way 2 gives 2,0,1,3.
  - A hit on way 3 gives 3,2,0,1.
  - A miss evicts way 1 and gives 1,3,2,0.
  - A hit on way 2 gives 2,1,3,0.
  - A miss evicts way 0 and gives 0,2,1,3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_hit | input | 1 | 1 means hit on `acc_way`, 0 means miss and refill of the victim |
| acc_way | input | WAY_W | Way number of a hit; ignored on a miss |
| victim_way | output | WAY_W | Way held in the least recent position |
| order_flat | output | N_WAYS*WAY_W | Full stack, position 0 in the low bits |

## Verification
The bench builds the tracker with the default of four ways and a 2-bit way number. With that size every stack position can be reached within a few accesses. The bench drives hits at the top, in the middle and at the bottom of the stack, and it drives misses with every value on `acc_way`. A long pseudo-random walk of hits, misses and idle cycles is checked against a model in the bench. The walk passes through many of the 24 possible orders, and the model checks that each one stays a permutation.

// File: rtl/lru_pkg.sv
package lru_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_HIT  = 2'd1,
    ACC_MISS = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/lru_way_locate.sv
module lru_way_locate #(
  parameter int N_WAYS = 4,
  localparam int WAY_W = $clog2(N_WAYS)
) (
  input  logic [N_WAYS*WAY_W-1:0] order_flat,
  input  logic [WAY_W-1:0]        way,
  output logic [N_WAYS-1:0]       match,
  output logic [WAY_W-1:0]        pos
);

  genvar p;
  generate
    for (p = 0; p < N_WAYS; p++) begin : g_cmp
      assign match[p] = (order_flat[p*WAY_W +: WAY_W] == way);
    end
  endgenerate

  always_comb begin
    pos = '0;
    for (int i = 0; i < N_WAYS; i++) begin
      if (match[i]) pos = WAY_W'(i);
    end
  end

endmodule

// File: rtl/lru_order_next.sv
module lru_order_next #(
  parameter int N_WAYS = 4,
  localparam int WAY_W = $clog2(N_WAYS)
) (
  input  logic [N_WAYS*WAY_W-1:0] cur_flat,
  input  logic                    upd,
  input  logic [WAY_W-1:0]        tgt_pos,
  output logic [N_WAYS*WAY_W-1:0] nxt_flat
);

  logic [WAY_W-1:0] cur [N_WAYS];
  logic [WAY_W-1:0] promoted;

  genvar p;
  generate
    for (p = 0; p < N_WAYS; p++) begin : g_unpack
      assign cur[p] = cur_flat[p*WAY_W +: WAY_W];
    end
  endgenerate

  assign promoted = cur[tgt_pos];

  generate
    for (p = 0; p < N_WAYS; p++) begin : g_slot
      if (p == 0) begin : g_top
        assign nxt_flat[0 +: WAY_W] = upd ? promoted : cur[0];
      end else begin : g_rest
        assign nxt_flat[p*WAY_W +: WAY_W] =
          (upd && (tgt_pos >= WAY_W'(p))) ? cur[p-1] : cur[p];
      end
    end
  endgenerate

endmodule

// File: rtl/lru_order_tracker.sv
module lru_order_tracker #(
  parameter int N_WAYS = 4,
  localparam int WAY_W = $clog2(N_WAYS),
  localparam int ORD_W = N_WAYS * WAY_W,
  localparam int LRU_POS = N_WAYS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  output logic [WAY_W-1:0] victim_way,
  output logic [ORD_W-1:0] order_flat
);
  import lru_pkg::*;

  logic [ORD_W-1:0]  order_q;
  logic [ORD_W-1:0]  order_d;
  logic [ORD_W-1:0]  order_init;
  logic [N_WAYS-1:0] hit_match;
  logic [WAY_W-1:0]  hit_pos;
  logic [WAY_W-1:0]  tgt_pos;
  logic              upd;
  acc_kind_e         kind;

  genvar p;
  generate
    for (p = 0; p < N_WAYS; p++) begin : g_init
      assign order_init[p*WAY_W +: WAY_W] = WAY_W'(p);
    end
  endgenerate

  always_comb begin
    if (!acc_valid)   kind = ACC_IDLE;
    else if (acc_hit) kind = ACC_HIT;
    else              kind = ACC_MISS;
  end

  lru_way_locate #(.N_WAYS(N_WAYS)) u_locate (
    .order_flat (order_q),
    .way        (acc_way),
    .match      (hit_match),
    .pos        (hit_pos)
  );

  assign upd     = (kind != ACC_IDLE);
  assign tgt_pos = (kind == ACC_MISS) ? WAY_W'(LRU_POS) : hit_pos;

  lru_order_next #(.N_WAYS(N_WAYS)) u_next (
    .cur_flat (order_q),
    .upd      (upd),
    .tgt_pos  (tgt_pos),
    .nxt_flat (order_d)
  );

  always_ff @(posedge clk) begin
    if (rst) order_q <= order_init;
    else     order_q <= order_d;
  end

  assign order_flat = order_q;
  assign victim_way = order_q[LRU_POS*WAY_W +: WAY_W];

  // Permutation check (R6): every way number appears in exactly one stack position.
  logic [N_WAYS-1:0] way_seen;
  always_comb begin
    way_seen = '0;
    for (int i = 0; i < N_WAYS; i++) begin
      way_seen[order_q[i*WAY_W +: WAY_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      p_permutation_r6: assert (&way_seen)
        else $error("order is not a permutation");
    end
  end

  p_reset_order_r1: assert property (@(posedge clk)
    rst |=> (order_flat == order_init));

  p_hit_to_mru_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hit) |=> (order_flat[WAY_W-1:0] == $past(acc_way)));

  p_miss_victim_to_mru_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_hit) |=> (order_flat[WAY_W-1:0] == $past(victim_way)));

  p_idle_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(order_flat));

  p_single_match_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(hit_match) == 1);

endmodule

// File: tb/lru_order_tracker_tb.sv
`timescale 1ns/1ps
module lru_order_tracker_tb_top;

  localparam int NW = 4;
  localparam int WW = 2;
  localparam int OW = NW * WW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0;
  logic          acc_hit = 1'b0;
  logic [WW-1:0] acc_way = '0;
  logic [WW-1:0] victim_way;
  logic [OW-1:0] order_flat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mdl [NW];

  always #2 clk = ~clk;

  lru_order_tracker #(.N_WAYS(NW)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_hit    (acc_hit),
    .acc_way    (acc_way),
    .victim_way (victim_way),
    .order_flat (order_flat)
  );

  function automatic logic [OW-1:0] mdl_pack();
    logic [OW-1:0] v;
    for (int i = 0; i < NW; i++) v[i*WW +: WW] = WW'(mdl[i]);
    return v;
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < NW; i++) mdl[i] = i;
  endtask

  task automatic mdl_access(input bit hit, input int way);
    int k;
    int w;
    k = NW - 1;
    if (hit) begin
      for (int i = 0; i < NW; i++) if (mdl[i] == way) k = i;
    end
    w = mdl[k];
    for (int i = k; i > 0; i--) mdl[i] = mdl[i-1];
    mdl[0] = w;
  endtask

  task automatic chk_order(input logic [OW-1:0] exp, input string req);
    checks++;
    if (order_flat !== exp) begin
      errors++;
      $display("FAIL %s: order_flat actual %h expected %h", req, order_flat, exp);
    end
  endtask

  task automatic chk_victim(input logic [WW-1:0] exp, input string req);
    checks++;
    if (victim_way !== exp) begin
      errors++;
      $display("FAIL %s: victim_way actual %0d expected %0d", req, victim_way, exp);
    end
  endtask

  // Caller is at a negedge. Inputs are applied, the edge updates the order, and the
  // results are sampled at the next negedge.
  task automatic step(input bit v, input bit h, input int w);
    acc_valid = v;
    acc_hit = h;
    acc_way = WW'(w);
    @(negedge clk);
    acc_valid = 1'b0;
    if (v) mdl_access(h, w);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mdl_reset();
  endtask

  task automatic t_reset();
    do_reset();
    chk_order(8'hE4, "R1 reset order");
    chk_victim(2'd3, "R2 victim after reset");
  endtask

  task automatic t_doc_sequence();
    do_reset();
    step(1, 1, 2); chk_order(8'hD2, "R8 hit C");
    step(1, 1, 3); chk_order(8'h4B, "R8 hit D");
    chk_victim(2'd1, "R8 victim before E");
    step(1, 0, 0); chk_order(8'h2D, "R8 miss E");
    step(1, 1, 2); chk_order(8'h36, "R8 hit C again");
    chk_victim(2'd0, "R8 victim before G");
    step(1, 0, 3); chk_order(8'hD8, "R8 miss G");
  endtask

  task automatic t_hit_mru();
    do_reset();
    step(1, 1, 0); chk_order(8'hE4, "R7 hit on MRU way");
  endtask

  task automatic t_hit_positions();
    do_reset();
    step(1, 1, 1); chk_order(8'hE1, "R3 hit position 1");
    step(1, 1, 3); chk_order(8'h87, "R3 hit LRU position");
    chk_victim(2'd2, "R2 victim after LRU hit");
  endtask

  task automatic t_miss_ignores_way();
    for (int w = 0; w < NW; w++) begin
      do_reset();
      step(1, 0, w);
      chk_order(8'h93, "R4 miss ignores acc_way");
      chk_victim(2'd2, "R4 victim after miss");
    end
  endtask

  task automatic t_idle();
    do_reset();
    step(1, 1, 2);
    acc_way = 2'd3;
    acc_hit = 1'b1;
    repeat (3) @(negedge clk);
    chk_order(8'hD2, "R5 idle with hit pattern on inputs");
    acc_hit = 1'b0;
    repeat (2) @(negedge clk);
    chk_order(8'hD2, "R5 idle while refill pending");
  endtask

  task automatic t_reset_mid();
    do_reset();
    step(1, 0, 0);
    step(1, 1, 2);
    rst = 1'b1;
    acc_valid = 1'b1; acc_hit = 1'b1; acc_way = 2'd3;
    @(negedge clk);
    rst = 1'b0; acc_valid = 1'b0;
    mdl_reset();
    chk_order(8'hE4, "R1 reset overrides access");
  endtask

  task automatic t_random_walk();
    logic [15:0] lfsr;
    bit ok;
    lfsr = 16'hACE1;
    do_reset();
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[1], int'(lfsr[3:2]));
      chk_order(mdl_pack(), "R3 R4 R5 walk vs model");
      chk_victim(WW'(mdl[NW-1]), "R2 walk victim");
      ok = 1'b1;
      for (int a = 0; a < NW; a++)
        for (int b = a + 1; b < NW; b++)
          if (order_flat[a*WW +: WW] == order_flat[b*WW +: WW]) ok = 1'b0;
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL R6: duplicate way in order_flat actual %h expected a permutation", order_flat);
      end
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_doc_sequence();
    t_hit_mru();
    t_hit_positions();
    t_miss_ignores_way();
    t_idle();
    t_reset_mid();
    t_random_walk();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule